// File: doc/BRIEF.md
# Atomic Chunked Register Multiplexer

This block connects a narrow register bus (one address, a read strobe, a write strobe and data words of `DATA_W` bits) to a fixed set of peripheral registers. Each register may be wider than the bus. A register is cut into bus-width chunks, one per consecutive address. Shadow storage inside the block makes every wide register look atomic to software.

On reads, the first chunk takes a snapshot of the whole register and fires that register's read strobe once. Every later chunk returns its slice of the snapshot, not the live value. On writes, earlier chunks fill a write shadow. The final address of the register's span hands the assembled word to the register with a one-cycle write strobe.

The register map is fixed at elaboration. For each register it gives a width, a base address and an access code. A span alignment parameter rounds every register's span up to a power-of-two number of addresses, so a wider initiator can step through a register with a fixed number of bus writes.

Top module: `csr_chunk_mux`

## Requirements
- R1: A register of width w occupies ceil(w/DATA_W) chunk addresses starting at its base, with bits [DATA_W-1:0] at the base address. Its span is that count rounded up to a multiple of 2**ALIGN addresses.
- R2: A read strobe on a register's base address pulses exactly that register's read strobe in the same cycle. No other address of the span pulses it.
- R3: A read of any chunk returns the slice of the value captured at the most recent base-address read, even if the live register has changed since.
- R4: `csr_r_data` is valid in the cycle after `csr_r_stb` and is zero in every other cycle. It is also zero for unmapped addresses, for padding addresses inside a span and for write-only registers.
- R5: A write strobe on a non-final address of a writable register only updates the write shadow. No register write strobe follows.
- R6: A write strobe on the final address of a span raises the register's write strobe exactly one cycle later. The data presented is the shadow merged with the data of that final write, and bits above the register width are zero.
- R7: With ALIGN=2, a 24-bit register on an 8-bit bus commits on its 4th write, the one to the padding address. The first three writes commit nothing.
- R8: Reads and writes to unmapped addresses pulse no register strobe and change no register.
- R9: Access code bit 0 enables reads and bit 1 enables writes (1 = read-only, 2 = write-only, 3 = read/write). Read-only registers never receive a write strobe. Write-only registers never receive a read strobe.
- R10: A transaction abandoned part-way needs no recovery. A new base-address read captures afresh, and a new write sequence that reaches the final address commits the newly written chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | ADDR_W | Chunk address |
| csr_r_stb | input | 1 | Bus read strobe |
| csr_r_data | output | DATA_W | Read data, valid one cycle after the strobe |
| csr_w_stb | input | 1 | Bus write strobe |
| csr_w_data | input | DATA_W | Write data for the addressed chunk |
| elem_r_data | input | NREG*MAX_W | Live register values, register i at [i*MAX_W +: MAX_W] |
| elem_r_stb | output | NREG | Per-register read strobe (read side effects) |
| elem_w_stb | output | NREG | Per-register write strobe (commit) |
| elem_w_data | output | NREG*MAX_W | Committed value per register, register i at [i*MAX_W +: MAX_W] |

## Verification
A stale or corrupt read snapshot shows up as a wrong slice on `csr_r_data` one cycle after the second or later chunk read. A missed capture shows up as a read-strobe count that differs from the number of base-address reads. A corrupt write shadow stays hidden until the final-address write. It then shows in the committed word one cycle later, or as a strobe that fires on the wrong write. Decode faults show at once as nonzero read data for padding or unmapped addresses, or as a strobe on the wrong register.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;

    localparam int ACC_RD_BIT = 0;
    localparam int ACC_WR_BIT = 1;

    function automatic int chunks_of(input int width, input int bus_w);
        return (width + bus_w - 1) / bus_w;
    endfunction

    function automatic int span_of(input int width, input int bus_w, input int align);
        int unit;
        unit = 1 << align;
        return ((chunks_of(width, bus_w) + unit - 1) / unit) * unit;
    endfunction

endpackage

// File: rtl/csr_chunk_decode.sv
module csr_chunk_decode #(
    parameter int ADDR_W = 6,
    parameter int BASE   = 0,
    parameter int SPAN   = 1,
    parameter int NCH    = 1,
    parameter int IDX_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_first,
    output logic              is_last,
    output logic              in_data,
    output logic [IDX_W-1:0]  chunk
);
    localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] SPAN_X = (ADDR_W+1)'(SPAN);
    localparam logic [ADDR_W:0] LAST_X = (ADDR_W+1)'(SPAN - 1);
    localparam logic [ADDR_W:0] NCH_X  = (ADDR_W+1)'(NCH);

    logic [ADDR_W:0] offset;

    always_comb begin
        offset   = {1'b0, addr} - BASE_X;
        hit      = ({1'b0, addr} >= BASE_X) && (offset < SPAN_X);
        is_first = hit && (offset == '0);
        is_last  = hit && (offset == LAST_X);
        in_data  = hit && (offset < NCH_X);
        chunk    = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/csr_reg_slot.sv
module csr_reg_slot #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int MAX_W  = 32,
    parameter int WIDTH  = 8,
    parameter int BASE   = 0,
    parameter int ALIGN  = 0,
    parameter int ACC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              r_stb,
    input  logic              w_stb,
    input  logic [DATA_W-1:0] w_data,
    input  logic [MAX_W-1:0]  live_value,
    output logic              reg_r_stb,
    output logic              reg_w_stb,
    output logic [MAX_W-1:0]  reg_w_data,
    output logic [DATA_W-1:0] rd_out
);
    import csr_mux_pkg::*;

    localparam int MAX_CH = MAX_W / DATA_W;
    localparam int IDX_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;
    localparam int NCH    = chunks_of(WIDTH, DATA_W);
    localparam int SPAN   = span_of(WIDTH, DATA_W, ALIGN);
    localparam bit CAN_RD = ACC[ACC_RD_BIT];
    localparam bit CAN_WR = ACC[ACC_WR_BIT];
    localparam logic [MAX_W-1:0] MASK = {MAX_W{1'b1}} >> (MAX_W - WIDTH);

    typedef logic [MAX_CH-1:0][DATA_W-1:0] chunks_t;

    typedef struct packed {
        chunks_t           rd_shadow;
        chunks_t           wr_shadow;
        logic [DATA_W-1:0] rdata;
        logic              wstb;
        logic [MAX_W-1:0]  wdata;
    } slot_st_t;

    slot_st_t st_q, st_d;

    logic             hit, is_first, is_last, in_data;
    logic [IDX_W-1:0] chunk;
    chunks_t          live_chunks;
    chunks_t          merged;

    csr_chunk_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .SPAN(SPAN), .NCH(NCH), .IDX_W(IDX_W)
    ) u_dec (
        .addr(addr), .hit(hit), .is_first(is_first), .is_last(is_last),
        .in_data(in_data), .chunk(chunk)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.wstb   = 1'b0;
        reg_r_stb   = 1'b0;
        live_chunks = chunks_t'(live_value & MASK);
        merged      = st_q.wr_shadow;

        if (CAN_RD && r_stb && in_data) begin
            if (is_first) begin
                st_d.rd_shadow = live_chunks;
                st_d.rdata     = live_chunks[0];
                reg_r_stb      = 1'b1;
            end else begin
                st_d.rdata = st_q.rd_shadow[chunk];
            end
        end

        if (CAN_WR && w_stb && hit) begin
            if (in_data) begin
                merged[chunk] = w_data;
            end
            st_d.wr_shadow = merged;
            if (is_last) begin
                st_d.wstb  = 1'b1;
                st_d.wdata = MAX_W'(merged) & MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_w_stb  = st_q.wstb;
    assign reg_w_data = st_q.wdata;
    assign rd_out     = st_q.rdata;
endmodule

// File: rtl/csr_chunk_mux.sv
module csr_chunk_mux #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int MAX_W  = 32,
    parameter int ALIGN  = 2,
    parameter int NREG   = 4,
    parameter int REG_WIDTH [NREG] = '{24, 16, 8, 32},
    parameter int REG_BASE  [NREG] = '{0, 4, 8, 12},
    parameter int REG_ACC   [NREG] = '{3, 1, 2, 3}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     csr_addr,
    input  logic                  csr_r_stb,
    output logic [DATA_W-1:0]     csr_r_data,
    input  logic                  csr_w_stb,
    input  logic [DATA_W-1:0]     csr_w_data,
    input  logic [NREG*MAX_W-1:0] elem_r_data,
    output logic [NREG-1:0]       elem_r_stb,
    output logic [NREG-1:0]       elem_w_stb,
    output logic [NREG*MAX_W-1:0] elem_w_data
);
    logic [DATA_W-1:0] slot_rd [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        csr_reg_slot #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_W(MAX_W),
            .WIDTH(REG_WIDTH[g]), .BASE(REG_BASE[g]), .ALIGN(ALIGN), .ACC(REG_ACC[g])
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr       (csr_addr),
            .r_stb      (csr_r_stb),
            .w_stb      (csr_w_stb),
            .w_data     (csr_w_data),
            .live_value (elem_r_data[g*MAX_W +: MAX_W]),
            .reg_r_stb  (elem_r_stb[g]),
            .reg_w_stb  (elem_w_stb[g]),
            .reg_w_data (elem_w_data[g*MAX_W +: MAX_W]),
            .rd_out     (slot_rd[g])
        );
    end

    always_comb begin
        csr_r_data = '0;
        for (int i = 0; i < NREG; i++) begin
            csr_r_data = csr_r_data | slot_rd[i];
        end
    end
endmodule

// File: rtl/csr_chunk_mux_chk.sv
module csr_chunk_mux_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int MAX_W  = 32,
    parameter int ALIGN  = 2,
    parameter int NREG   = 4,
    parameter int REG_WIDTH [NREG] = '{24, 16, 8, 32},
    parameter int REG_BASE  [NREG] = '{0, 4, 8, 12},
    parameter int REG_ACC   [NREG] = '{3, 1, 2, 3}
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     csr_addr,
    input logic                  csr_r_stb,
    input logic [DATA_W-1:0]     csr_r_data,
    input logic                  csr_w_stb,
    input logic [DATA_W-1:0]     csr_w_data,
    input logic [NREG*MAX_W-1:0] elem_r_data,
    input logic [NREG-1:0]       elem_r_stb,
    input logic [NREG-1:0]       elem_w_stb,
    input logic [NREG*MAX_W-1:0] elem_w_data
);
    import csr_mux_pkg::*;

    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(csr_addr) >= REG_BASE[i] &&
                int'(csr_addr) < REG_BASE[i] + span_of(REG_WIDTH[i], DATA_W, ALIGN)) begin
                mapped = 1'b1;
            end
        end
    end

    a_r4_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_r_stb |=> (csr_r_data == '0));

    a_r2_rstb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_r_stb));

    a_r2_rstb_needs_bus_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|elem_r_stb) |-> csr_r_stb);

    a_r6_commit_one_cycle_late: assert property (@(posedge clk) disable iff (!rst_n)
        (|elem_w_stb) |-> $past(csr_w_stb));

    a_r6_commit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_w_stb));

    a_r8_unmapped_no_rstb: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_r_stb && !mapped) |-> (elem_r_stb == '0));

    a_r8_unmapped_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_w_stb && !mapped) |=> (elem_w_stb == '0));
endmodule

bind csr_chunk_mux csr_chunk_mux_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_W(MAX_W), .ALIGN(ALIGN), .NREG(NREG),
    .REG_WIDTH(REG_WIDTH), .REG_BASE(REG_BASE), .REG_ACC(REG_ACC)
) u_chk (.*);

// File: tb/csr_chunk_mux_tb.sv
module csr_chunk_mux_tb_top;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int MAX_W  = 32;
    localparam int NREG   = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [ADDR_W-1:0]     csr_addr = '0;
    logic                  csr_r_stb = 1'b0;
    logic [DATA_W-1:0]     csr_r_data;
    logic                  csr_w_stb = 1'b0;
    logic [DATA_W-1:0]     csr_w_data = '0;
    logic [NREG*MAX_W-1:0] elem_r_data;
    logic [NREG-1:0]       elem_r_stb;
    logic [NREG-1:0]       elem_w_stb;
    logic [NREG*MAX_W-1:0] elem_w_data;

    logic [MAX_W-1:0] live [NREG];
    int               rcnt [NREG];
    int               ccnt [NREG];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic rd_pend = 1'b0;
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];
    logic [NREG-1:0]   seen;

    always #5 clk = ~clk;

    csr_chunk_mux dut_i (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_r_stb(csr_r_stb),
        .csr_r_data(csr_r_data), .csr_w_stb(csr_w_stb), .csr_w_data(csr_w_data),
        .elem_r_data(elem_r_data), .elem_r_stb(elem_r_stb), .elem_w_stb(elem_w_stb),
        .elem_w_data(elem_w_data)
    );

    always_comb begin
        for (int i = 0; i < NREG; i++) elem_r_data[i*MAX_W +: MAX_W] = live[i];
    end

    // Peripheral model: counts strobes, takes committed values
    always @(posedge clk) begin
        rd_pend <= csr_r_stb;
        for (int i = 0; i < NREG; i++) begin
            if (elem_r_stb[i]) rcnt[i] <= rcnt[i] + 1;
            if (elem_w_stb[i]) begin
                ccnt[i] <= ccnt[i] + 1;
                live[i] <= elem_w_data[i*MAX_W +: MAX_W];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data one cycle after each read strobe
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), 32'(csr_r_data), 32'(exp_q.pop_front()));
        end
    end

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        csr_addr  = ADDR_W'(a);
        csr_r_stb = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        csr_r_stb = 1'b0;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        csr_addr   = ADDR_W'(a);
        csr_w_data = d;
        csr_w_stb  = 1'b1;
        @(negedge clk);
        csr_w_stb  = 1'b0;
        seen       = elem_w_stb;
    endtask

    task automatic idle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            live[i] = '0; rcnt[i] = 0; ccnt[i] = 0;
        end
        live[0] = 32'h00A1B2C3;
        live[1] = 32'h0000BEEF;
        repeat (3) @(negedge clk);
        chk("R4 reset r_data", 32'(csr_r_data), 32'h0);
        chk("R2 reset r_stb", 32'(elem_r_stb), 32'h0);
        chk("R6 reset w_stb", 32'(elem_w_stb), 32'h0);
        rst_n = 1'b1;

        // Atomic read of 24-bit register, live value changed mid-read
        rd(0, 8'hC3, "R1 reg0 chunk0");
        chk("R2 reg0 read strobe once", rcnt[0], 1);
        live[0] = 32'h00112233;
        rd(1, 8'hB2, "R3 reg0 chunk1 from snapshot");
        rd(2, 8'hA1, "R3 reg0 chunk2 from snapshot");
        rd(3, 8'h00, "R4 reg0 padding");
        chk("R2 no strobe on later chunks", rcnt[0], 1);

        rd(4, 8'hEF, "R1 reg1 chunk0");
        rd(5, 8'hBE, "R1 reg1 chunk1");
        rd(6, 8'h00, "R4 reg1 padding");
        rd(8, 8'h00, "R9 write-only reads zero");
        chk("R9 write-only no read strobe", rcnt[2], 0);
        rd(20, 8'h00, "R8 unmapped read zero");
        chk("R8 unmapped read no strobe", rcnt[0] + rcnt[1] + rcnt[2] + rcnt[3], 2);

        // Aligned write: commit on 4th write
        wr(0, 8'h11); chk("R5 chunk0 no commit", 32'(seen), 32'h0);
        wr(1, 8'h22); chk("R5 chunk1 no commit", 32'(seen), 32'h0);
        wr(2, 8'h33); chk("R7 3rd write no commit", 32'(seen), 32'h0);
        chk("R5 register untouched", live[0], 32'h00112233);
        wr(3, 8'hFF); chk("R7 commit on 4th write", 32'(seen), 32'h1);
        idle();
        chk("R6 committed value", live[0], 32'h00332211);

        // Full-width register, final chunk data merged
        wr(12, 8'h44); wr(13, 8'h55); wr(14, 8'h66);
        wr(15, 8'h77); chk("R6 reg3 commit next cycle", 32'(seen), 32'h8);
        idle();
        chk("R6 reg3 merged final chunk", live[3], 32'h77665544);
        rd(12, 8'h44, "R6 reg3 readback chunk0");
        rd(15, 8'h77, "R6 reg3 readback chunk3");

        // Read-only register ignores writes
        wr(4, 8'h01); wr(5, 8'h02); wr(6, 8'h03);
        wr(7, 8'h04); chk("R9 read-only no commit", 32'(seen), 32'h0);
        rd(4, 8'hEF, "R9 read-only unchanged lo");
        rd(5, 8'hBE, "R9 read-only unchanged hi");

        // Write-only register, upper bits zero
        wr(8, 8'h5A); wr(9, 8'h00); wr(10, 8'h00);
        wr(11, 8'h00); chk("R6 reg2 commit at padded end", 32'(seen), 32'h4);
        idle();
        chk("R6 reg2 bits above width zero", live[2], 32'h0000005A);

        // Unmapped write
        wr(30, 8'hEE); chk("R8 unmapped write no commit", 32'(seen), 32'h0);
        chk("R8 commit counts unchanged", ccnt[0] + ccnt[1] + ccnt[2] + ccnt[3], 3);
        rd(0, 8'h11, "R8 reg0 intact");

        // Abandoned transactions
        wr(0, 8'hAA);
        wr(0, 8'h01); wr(1, 8'h02); wr(2, 8'h03);
        wr(3, 8'h00); chk("R10 restarted write commits", 32'(seen), 32'h1);
        idle();
        chk("R10 restarted write value", live[0], 32'h00030201);
        live[0] = 32'h00CCBBAA;
        rd(0, 8'hAA, "R10 recapture chunk0");
        rd(1, 8'hBB, "R10 recapture chunk1");
        chk("R2 strobe per base read", rcnt[0], 3);

        idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule